// File: doc/BRIEF.md
# 8b/10b Line Symbol Decoder

This block turns one 10-bit line symbol back into the byte it carries. It also returns a flag that marks control characters. It is purely combinational: a symbol and the running disparity that applied before it go in, and the same evaluation gives the decoded value, the running disparity after the symbol, and two independent error flags.

- The code-error flag marks a pattern that is not a valid symbol under either disparity.
- The disparity-error flag marks a valid symbol that arrived under the wrong starting disparity.

Decoding works in two steps. First the 6-bit and 4-bit sub-blocks are mapped back to a candidate value. The primary and alternate forms of the y=7 sub-block are both accepted, and the complemented control forms that follow the negative control 6-bit code are accepted too. The candidate is then encoded again under both starting disparities and compared with the input symbol. That comparison alone decides legality, so the error flags follow directly from the set of legal symbols, not from a hand-written list of exceptions.

Top module: `line_symbol_decoder`

## Requirements
- R1: The symbol is ordered {j,h,g,f,i,e,d,c,b,a} with a at bit 0. The result is {K,H,G,F,E,D,C,B,A} with A at bit 0. Every data character Dx.y (value {0,y,x}), encoded under either starting disparity, decodes to its own value.
- R2: Exactly twelve control characters decode with bit 8 set: K28.0 to K28.7, and K23.7, K27.7, K29.7 and K30.7.
- R3: A y=7 byte coded in the alternate 3b/4b form decodes to the same value as the primary form. The alternate form is used by D17/D18/D20 after a negative 6b sub-block, by D11/D13/D14 after a positive one, and by every control character with y=7.
- R4: Any 10-bit pattern that is not the encoding of one of the 268 values under either starting disparity sets the code-error flag, whatever the disparity input. A valid symbol never sets it.
- R5: For a valid symbol, the disparity-error flag is 1 exactly when the symbol is not the encoding for the given starting disparity (rd_i 0 means negative, 1 means positive).
- R6: For a valid symbol at a legal starting disparity, the ending disparity equals the starting disparity if the symbol holds five ones, and is inverted otherwise.
- R7: For any other input, the ending disparity is 1 above five ones, 0 below five ones, and equal to rd_i at exactly five.
- R8: After the negative control 6b code (abcdei = 110000), the balanced 4b codes of K28.1, K28.2, K28.5 and K28.6 appear complemented. They still decode to those control values and not to the data value that shares the nibble.
- R9: A symbol whose 6b sub-block has fewer than two or more than four ones, or whose 4b sub-block has no ones or four ones, is never accepted as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sym_i | input | 10 | Line symbol {j,h,g,f,i,e,d,c,b,a} |
| rd_i | input | 1 | Running disparity before the symbol (0 negative, 1 positive) |
| data_o | output | 9 | Decoded value {K,H..A}; don't-care when code_err_o is 1 |
| rd_o | output | 1 | Running disparity after the symbol |
| code_err_o | output | 1 | Symbol is not a valid code under either disparity |
| disp_err_o | output | 1 | Valid symbol under the wrong starting disparity; don't-care when code_err_o is 1 |

## Verification
The block holds no state, so any fault appears in the same evaluation as the symbol that triggers it.

- A fault in the sub-block reverse mapping shows up on a legal symbol as a wrong data_o. It also raises a spurious code error, because the wrongly decoded candidate no longer encodes back to the input.
- A fault in the re-encoding path shows up differently. Legal symbols are flagged, or illegal ones, such as the primary y=7 form where the alternate is required, pass silently.

The sweeps therefore cover every pattern under both disparities, and they watch the flags and the ending disparity as closely as the decoded value.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   localparam int unsigned SYM_W  = 10;
   localparam int unsigned VAL_W  = 9;
   localparam int unsigned SIX_W  = 6;
   localparam int unsigned FOUR_W = 4;
   localparam int unsigned X_W    = 5;
   localparam int unsigned Y_W    = 3;
   localparam int unsigned NUM_X  = 1 << X_W;
   localparam int unsigned NUM_Y  = 1 << Y_W;

   // Sub-block literals below are written in port bit order:
   // 6b as {i,e,d,c,b,a}, 4b as {j,h,g,f}.
   localparam logic [SIX_W-1:0]  SIX_CTRL  = 6'b111100;  // control 28, negative-start form
   localparam logic [FOUR_W-1:0] FOUR_ALT7 = 4'b1110;    // alternate y=7, negative form

   // 6b codeword for the negative-start form of data value x
   function automatic logic [SIX_W-1:0] six_base(input logic [X_W-1:0] x);
      logic [SIX_W-1:0] c;
      case (x)
         5'd0:  c = 6'b111001;
         5'd1:  c = 6'b101110;
         5'd2:  c = 6'b101101;
         5'd3:  c = 6'b100011;
         5'd4:  c = 6'b101011;
         5'd5:  c = 6'b100101;
         5'd6:  c = 6'b100110;
         5'd7:  c = 6'b000111;
         5'd8:  c = 6'b100111;
         5'd9:  c = 6'b101001;
         5'd10: c = 6'b101010;
         5'd11: c = 6'b001011;
         5'd12: c = 6'b101100;
         5'd13: c = 6'b001101;
         5'd14: c = 6'b001110;
         5'd15: c = 6'b111010;
         5'd16: c = 6'b110110;
         5'd17: c = 6'b110001;
         5'd18: c = 6'b110010;
         5'd19: c = 6'b010011;
         5'd20: c = 6'b110100;
         5'd21: c = 6'b010101;
         5'd22: c = 6'b010110;
         5'd23: c = 6'b010111;
         5'd24: c = 6'b110011;
         5'd25: c = 6'b011001;
         5'd26: c = 6'b011010;
         5'd27: c = 6'b011011;
         5'd28: c = 6'b011100;
         5'd29: c = 6'b011101;
         5'd30: c = 6'b011110;
         default: c = 6'b110101;
      endcase
      return c;
   endfunction

   // 4b codeword for the negative-start form of y (primary coding)
   function automatic logic [FOUR_W-1:0] four_base(input logic [Y_W-1:0] y);
      logic [FOUR_W-1:0] c;
      case (y)
         3'd0: c = 4'b1101;
         3'd1: c = 4'b1001;
         3'd2: c = 4'b1010;
         3'd3: c = 4'b0011;
         3'd4: c = 4'b1011;
         3'd5: c = 4'b0101;
         3'd6: c = 4'b0110;
         default: c = 4'b0111;
      endcase
      return c;
   endfunction

   // x values that form a y=7 control character with the ordinary 6b code
   function automatic logic ctrl7_x(input logic [X_W-1:0] x);
      return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
   endfunction

endpackage

// File: rtl/lsd_six_dec.sv
module lsd_six_dec
   import lsd_pkg::*;
(
   input  logic [SIX_W-1:0] six_i,
   output logic [X_W-1:0]   x_o,
   output logic             ctrl_o,
   output logic             ctrl_neg_o
);
   logic [NUM_X-1:0] hit;

   for (genvar v = 0; v < NUM_X; v++) begin : g_cand
      logic [SIX_W-1:0] neg_c;
      logic [SIX_W-1:0] pos_c;
      logic             keep;
      assign neg_c = six_base(X_W'(v));
      assign keep  = ($countones(neg_c) == 3) && (v != 7);
      assign pos_c = keep ? neg_c : ~neg_c;
      assign hit[v] = (six_i == neg_c) || (six_i == pos_c);
   end

   always_comb begin
      x_o = '0;
      for (int v = 0; v < NUM_X; v++)
         if (hit[v]) x_o = x_o | X_W'(v);
   end

   assign ctrl_neg_o = (six_i == ~SIX_CTRL);
   assign ctrl_o     = (six_i == SIX_CTRL) || ctrl_neg_o;

endmodule

// File: rtl/lsd_four_dec.sv
module lsd_four_dec
   import lsd_pkg::*;
(
   input  logic [FOUR_W-1:0] nib_i,
   input  logic              flip_i,
   output logic [Y_W-1:0]    y_o,
   output logic              alt_o
);
   logic [FOUR_W-1:0] eff;
   logic [NUM_Y-1:0]  hit;

   // balanced nibbles after the negative control code are seen complemented
   assign eff = (flip_i && ($countones(nib_i) == 2)) ? ~nib_i : nib_i;

   for (genvar y = 0; y < NUM_Y; y++) begin : g_cand
      logic [FOUR_W-1:0] neg_c;
      logic              keep;
      assign neg_c  = four_base(Y_W'(y));
      assign keep   = ($countones(neg_c) == 2) && (y != 3);
      assign hit[y] = (eff == neg_c) || (eff == (keep ? neg_c : ~neg_c));
   end

   assign alt_o = (eff == FOUR_ALT7) || (eff == ~FOUR_ALT7);

   always_comb begin
      y_o = '0;
      for (int y = 0; y < NUM_Y; y++)
         if (hit[y]) y_o = y_o | Y_W'(y);
      if (alt_o) y_o = '1;
   end

endmodule

// File: rtl/lsd_reenc.sv
module lsd_reenc
   import lsd_pkg::*;
#(
   parameter bit RD_START = 1'b0
) (
   input  logic [VAL_W-1:0] val_i,
   output logic [SYM_W-1:0] sym_o
);
   logic [X_W-1:0]    x;
   logic [Y_W-1:0]    y;
   logic              k;
   logic [SIX_W-1:0]  c6n, c6;
   logic [FOUR_W-1:0] c4n;
   logic              bal6, bal4, mid, use_alt, inv4;

   assign x = val_i[X_W-1:0];
   assign y = val_i[X_W+Y_W-1:X_W];
   assign k = val_i[VAL_W-1];

   assign c6n  = (k && x == 5'd28) ? SIX_CTRL : six_base(x);
   assign bal6 = ($countones(c6n) == 3);
   assign c6   = (!RD_START || (bal6 && x != 5'd7)) ? c6n : ~c6n;
   assign mid  = bal6 ? RD_START : !RD_START;

   // alternate y=7 whenever the primary form would extend a run of e,i
   assign use_alt = (y == 3'd7) &&
                    (k || (mid ? (!c6[4] && !c6[5]) : (c6[4] && c6[5])));
   assign c4n  = use_alt ? FOUR_ALT7 : four_base(y);
   assign bal4 = ($countones(c4n) == 2);
   assign inv4 = (bal4 && y != 3'd3) ? (k && !mid) : mid;

   assign sym_o = {(inv4 ? ~c4n : c4n), c6};

endmodule

// File: rtl/line_symbol_decoder.sv
module line_symbol_decoder
   import lsd_pkg::*;
#(
   parameter int unsigned SYM_BITS = lsd_pkg::SYM_W,
   parameter int unsigned VAL_BITS = lsd_pkg::VAL_W
) (
   input  logic [SYM_BITS-1:0] sym_i,
   input  logic                rd_i,
   output logic [VAL_BITS-1:0] data_o,
   output logic                rd_o,
   output logic                code_err_o,
   output logic                disp_err_o
);
   localparam int unsigned NUM_RD  = 2;
   localparam int unsigned ONES_W  = $clog2(SYM_BITS + 1);
   localparam int unsigned HALF    = SYM_BITS / 2;

   if (SYM_BITS != SYM_W || VAL_BITS != VAL_W) begin : g_bad_width
      $error("line_symbol_decoder: widths fixed at 10 in, 9 out");
   end

   logic [X_W-1:0]     x_raw, x_c;
   logic [Y_W-1:0]     y;
   logic               ctrl28, ctrl28_neg, alt7, k;
   logic [VAL_W-1:0]   cand;
   logic [NUM_RD-1:0]  legal;
   logic [ONES_W-1:0]  ones;

   lsd_six_dec u_six (
      .six_i      (sym_i[SIX_W-1:0]),
      .x_o        (x_raw),
      .ctrl_o     (ctrl28),
      .ctrl_neg_o (ctrl28_neg)
   );

   lsd_four_dec u_four (
      .nib_i  (sym_i[SYM_W-1:SIX_W]),
      .flip_i (ctrl28_neg),
      .y_o    (y),
      .alt_o  (alt7)
   );

   assign x_c  = ctrl28 ? 5'd28 : x_raw;
   assign k    = ctrl28 || (alt7 && ctrl7_x(x_raw));
   assign cand = {k, y, x_c};

   for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      logic [SYM_W-1:0] enc;
      lsd_reenc #(.RD_START(r == 1)) u_enc (
         .val_i (cand),
         .sym_o (enc)
      );
      assign legal[r] = (enc == sym_i);
   end

   assign ones       = ONES_W'($countones(sym_i));
   assign code_err_o = ~|legal;
   assign disp_err_o = !code_err_o && !legal[rd_i];
   assign rd_o       = (ones > ONES_W'(HALF)) ? 1'b1 :
                       (ones < ONES_W'(HALF)) ? 1'b0 : rd_i;
   assign data_o     = cand;

endmodule

// File: rtl/line_symbol_decoder_chk.sv
module line_symbol_decoder_chk (
   input logic [9:0] sym_i,
   input logic       rd_i,
   input logic [8:0] data_o,
   input logic       rd_o,
   input logic       code_err_o,
   input logic       disp_err_o
);
   always_comb begin
      // R9
      six_weight_chk: assert (code_err_o ||
         ($countones(sym_i[5:0]) >= 2 && $countones(sym_i[5:0]) <= 4));
      // R9
      four_weight_chk: assert (code_err_o ||
         ($countones(sym_i[9:6]) >= 1 && $countones(sym_i[9:6]) <= 3));
      // R5
      start_side_chk: assert (code_err_o || disp_err_o ||
         (rd_i ? ($countones(sym_i) <= 5) : ($countones(sym_i) >= 5)));
      // R6
      legal_flip_chk: assert (code_err_o || disp_err_o ||
         ($countones(sym_i) == 5) || (rd_o != rd_i));
      // R7
      balanced_keep_chk: assert (($countones(sym_i) != 5) || (rd_o == rd_i));
      // R2
      ctrl_shape_chk: assert (code_err_o || !data_o[8] ||
         (data_o[4:0] == 5'd28) || (data_o[7:5] == 3'd7));
   end
endmodule

bind line_symbol_decoder line_symbol_decoder_chk chk_i (
   .sym_i      (sym_i),
   .rd_i       (rd_i),
   .data_o     (data_o),
   .rd_o       (rd_o),
   .code_err_o (code_err_o),
   .disp_err_o (disp_err_o)
);

// File: tb/line_symbol_decoder_tb_top.sv
`timescale 1ns/1ps
module line_symbol_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] sym;
   logic       rd_in;
   logic [8:0] data;
   logic       rd_out, code_err, disp_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [1023:0] legal0, legal1;
   logic [8:0]    map_q [1024];

   always #2.5 clk = ~clk;

   line_symbol_decoder dut_i (
      .sym_i      (sym),
      .rd_i       (rd_in),
      .data_o     (data),
      .rd_o       (rd_out),
      .code_err_o (code_err),
      .disp_err_o (disp_err)
   );

   // 6b codes written abcdei, a leftmost
   function automatic logic [5:0] six_abcdei(input int x);
      case (x)
         0: return 6'b100111;   1: return 6'b011101;   2: return 6'b101101;
         3: return 6'b110001;   4: return 6'b110101;   5: return 6'b101001;
         6: return 6'b011001;   7: return 6'b111000;   8: return 6'b111001;
         9: return 6'b100101;  10: return 6'b010101;  11: return 6'b110100;
        12: return 6'b001101;  13: return 6'b101100;  14: return 6'b011100;
        15: return 6'b010111;  16: return 6'b011011;  17: return 6'b100011;
        18: return 6'b010011;  19: return 6'b110010;  20: return 6'b001011;
        21: return 6'b101010;  22: return 6'b011010;  23: return 6'b111010;
        24: return 6'b110011;  25: return 6'b100110;  26: return 6'b010110;
        27: return 6'b110110;  28: return 6'b001110;  29: return 6'b101110;
        30: return 6'b011110;  default: return 6'b101011;
      endcase
   endfunction

   // 4b codes written fghj, f leftmost
   function automatic logic [3:0] four_fghj(input int y, input bit alt);
      if (alt) return 4'b0111;
      case (y)
         0: return 4'b1011;  1: return 4'b1001;  2: return 4'b0101;
         3: return 4'b1100;  4: return 4'b1101;  5: return 4'b1010;
         6: return 4'b0110;  default: return 4'b1110;
      endcase
   endfunction

   // returns {rd_after, symbol}
   function automatic logic [10:0] model_enc(input logic [8:0] v, input logic rd);
      int x, y;
      bit k, alt, mid, rdo;
      logic [5:0] s6;
      logic [3:0] s4;
      logic [9:0] s;
      x = int'(v[4:0]);
      y = int'(v[7:5]);
      k = v[8];
      s6 = (k && x == 28) ? 6'b001111 : six_abcdei(x);
      mid = rd;
      if ($countones(s6) != 3) mid = !rd;
      if (rd && ($countones(s6) != 3 || x == 7)) s6 = ~s6;
      alt = (y == 7) && (k || (!mid && (x == 17 || x == 18 || x == 20)) ||
                         (mid && (x == 11 || x == 13 || x == 14)));
      s4 = four_fghj(y, alt);
      if (k && !mid && (y == 1 || y == 2 || y == 5 || y == 6)) s4 = ~s4;
      else if (mid && ($countones(s4) != 2 || y == 3)) s4 = ~s4;
      rdo = ($countones(s4) == 2) ? mid : !mid;
      s = {s4[0], s4[1], s4[2], s4[3], s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};
      return {rdo, s};
   endfunction

   function automatic logic [8:0] value_of(input int idx);
      int j;
      if (idx < 256) return 9'(idx);
      j = idx - 256;
      if (j < 8) return {1'b1, 3'(j), 5'd28};
      case (j)
         8: return {1'b1, 3'd7, 5'd23};
         9: return {1'b1, 3'd7, 5'd27};
        10: return {1'b1, 3'd7, 5'd29};
        default: return {1'b1, 3'd7, 5'd30};
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s sym=%b rd=%0d actual=%0h expected=%0h", tag, sym, rd_in, act, exp);
      end
   endtask

   task automatic apply(input logic [9:0] s, input logic r);
      @(posedge clk);
      sym   = s;
      rd_in = r;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      sym = 10'd0;
      rd_in = 1'b0;
      legal0 = '0;
      legal1 = '0;
      for (int i = 0; i < 1024; i++) map_q[i] = '0;
      repeat (3) @(negedge clk);
      // R4: all-zero pattern during reset is not a code
      chk(code_err == 1'b1, "R4 reset", int'(code_err), 1);
      rst_n = 1'b1;

      // round trip of all 268 values at both starting disparities
      for (int idx = 0; idx < 268; idx++) begin
         for (int r = 0; r < 2; r++) begin
            logic [8:0]  v;
            logic [10:0] m;
            string       tag;
            v = value_of(idx);
            m = model_enc(v, r[0]);
            if (r == 0) legal0[m[9:0]] = 1'b1; else legal1[m[9:0]] = 1'b1;
            map_q[m[9:0]] = v;
            apply(m[9:0], r[0]);
            if (v[8] && v[4:0] == 5'd28 && r == 1) tag = "R8";
            else if (v[8]) tag = "R2";
            else if (v[7:5] == 3'd7 && ((r == 0 && (v[4:0] == 5'd17 || v[4:0] == 5'd18 || v[4:0] == 5'd20)) ||
                                        (r == 1 && (v[4:0] == 5'd11 || v[4:0] == 5'd13 || v[4:0] == 5'd14))))
               tag = "R3";
            else tag = "R1";
            chk(data == v, tag, int'(data), int'(v));
            chk(code_err == 1'b0, "R4 valid", int'(code_err), 0);
            chk(disp_err == 1'b0, "R5 legal", int'(disp_err), 0);
            chk(rd_out == m[10], "R6", int'(rd_out), int'(m[10]));
         end
      end

      // every pattern at both disparities
      for (int p = 0; p < 1024; p++) begin
         for (int r = 0; r < 2; r++) begin
            bit here, there, any;
            int ones;
            bit exp_rd;
            here  = (r == 0) ? legal0[p] : legal1[p];
            there = (r == 0) ? legal1[p] : legal0[p];
            any   = here || there;
            apply(10'(p), r[0]);
            chk(code_err == !any, "R4 sweep", int'(code_err), int'(!any));
            if (any) begin
               chk(data == map_q[p], "R1 sweep", int'(data), int'(map_q[p]));
               chk(disp_err == !here, "R5 sweep", int'(disp_err), int'(!here));
            end
            ones = $countones(10'(p));
            exp_rd = (ones > 5) ? 1'b1 : (ones < 5) ? 1'b0 : r[0];
            if (here) chk(rd_out == exp_rd, "R6 sweep", int'(rd_out), int'(exp_rd));
            else      chk(rd_out == exp_rd, "R7 sweep", int'(rd_out), int'(exp_rd));
            if ($countones(10'(p) & 10'h3F) < 2 || $countones(10'(p) & 10'h3F) > 4 ||
                $countones(10'(p) >> 6) == 0 || $countones(10'(p) >> 6) == 4)
               chk(code_err == 1'b1, "R9", int'(code_err), 1);
         end
      end

      // named corners
      apply(10'b0110_000011, 1'b1);   // K28.1 after positive start
      chk(data == 9'h13C && !code_err, "R8 K28.1", int'(data), 'h13C);
      apply(10'b1110_110001, 1'b0);   // D17.7 alternate form
      chk(data == 9'h0F1 && !code_err, "R3 D17.7", int'(data), 'h0F1);
      apply(10'b0111_110001, 1'b0);   // D17.7 primary form: run of five
      chk(code_err == 1'b1, "R4 D17.P7", int'(code_err), 1);
      apply(10'b0111_110001, 1'b1);
      chk(code_err == 1'b1, "R4 D17.P7 pos", int'(code_err), 1);

      finish_run();
   end

endmodule